// File: doc/BRIEF.md
# Multi-Core Packet Sampler

This block decides, for every packet that passes a lookup stage, which of sixteen independent sampling policies select it. Each packet arrives as an opaque lookup record together with its length in bytes. An eight-entry synchronous FIFO absorbs these arrivals. The producer delivers no more than four records in any sixteen cycles, so one packet every four cycles keeps the FIFO from filling.

A small scheduler takes one packet from the FIFO, runs it through a fixed four-cycle window and broadcasts it to all sampling cores at once. At the end of the window it presents the record next to a vector that has one verdict bit per core. Each core is configured on its own through a word-addressed register port. The configuration sets whether the core is enabled, its policy and its threshold. A core can select every n-th packet, select the packet that carries every n-th byte, or select by comparing a per-core pseudo-random value with the threshold.

Top module: `pkt_sampler`

## Requirements
- R1: After reset, res_valid and in_full are 0, every core's control word and threshold read 0, every seed reads 1, and the status word reads 0.
- R2: The input FIFO holds 8 entries. in_full is 1 while 8 entries are held, and a write presented while in_full is 1 is discarded and never produces a result.
- R3: A discarded write sets status bit 0 (address bit 6 = 1). The bit stays set until reset.
- R4: A write into an empty FIFO on an idle unit yields a res_valid pulse exactly one cycle wide, starting three clock edges after the writing edge, with res_record equal to the written record. While entries wait, consecutive pulses are four cycles apart, and results leave in arrival order.
- R5: A core whose enable bit (control bit 0) is 0 reports 0 in its vector bit, and neither its counter nor its random state advances.
- R6: Mode 0 (control bits 2:1 = 0) counts packets, with the counter cleared by a control write. On each packet, counter+1 is compared with the threshold. When it is greater than or equal, the bit is 1 and the counter returns to 0. Otherwise the counter takes counter+1. With threshold n, every n-th packet is selected.
- R7: In mode 0 with threshold 1 or 0, every packet is selected.
- R8: Mode 1 accumulates bytes. The sum counter+length is compared with the threshold. When it is greater than or equal, the bit is 1 and the counter takes sum−threshold. Otherwise the counter takes the sum.
- R9: In mode 2, each packet first advances the core's 32-bit generator to (s>>1) XOR (s[0] ? 0x80200003 : 0). The bit is 1 when the new value is greater than or equal to the threshold.
- R10: A seed write loads the generator with the written value. A control write clears the core's counter and leaves the generator unchanged.
- R11: Mode 3 selects nothing: the bit is 0 and no state advances.
- R12: Address bits 5:2 pick the core and bits 1:0 pick the word: 0 is control (only bits 2:0 are kept and read back), 1 is threshold, 2 is seed. Read data is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Write one packet into the FIFO |
| in_record | input | 32 | Opaque lookup record |
| in_len | input | 16 | Packet length in bytes |
| in_full | output | 1 | FIFO holds 8 entries |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 7 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data |
| res_valid | output | 1 | One-cycle result strobe |
| res_vector | output | 16 | Per-core verdicts, bit i from core i |
| res_record | output | 32 | Record of the packet being reported |

## Verification
The hardest case to reach from the ports is a disabled or mode-3 core whose hidden random state must stay frozen. The bench leaves such cores seeded while many packets pass. It then switches them to mode 2 with a control write only, so that their first verdicts show whether the generator moved. Overflow is hard to reach because the scheduler drains one entry every four cycles. A burst of fourteen back-to-back writes fills the FIFO, and the scoreboard confirms that only the eleven accepted records come out.

// File: rtl/pkt_sampler_pkg.sv
package pkt_sampler_pkg;

  typedef enum logic [1:0] {
    MODE_COUNT  = 2'd0,
    MODE_BYTES  = 2'd1,
    MODE_RANDOM = 2'd2,
    MODE_OFF    = 2'd3
  } smp_mode_e;

  localparam int unsigned CFG_W = 32;
  localparam logic [CFG_W-1:0] GEN_TAPS = 32'h8020_0003;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_THR  = 2'd1;
  localparam logic [1:0] SEL_SEED = 2'd2;

endpackage

// File: rtl/sampler_fifo.sv
module sampler_fifo #(
  parameter int unsigned W     = 48,
  parameter int unsigned DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full,
  output logic         overflow
);
  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d;
  logic             do_push, do_pop;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rd_ptr_q];
  assign overflow = ovf_q;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    ovf_d    = ovf_q || (push && full);
    if (do_push) wr_ptr_d = wr_ptr_q + 1'b1;
    if (do_pop)  rd_ptr_d = rd_ptr_q + 1'b1;
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      ovf_q    <= 1'b0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
      ovf_q    <= ovf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr_q] <= wdata;
  end

  // R2: a write while full leaves the occupancy untouched
  assert_drop_when_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> (full && $stable(cnt_q)));
  // R2: occupancy never passes the depth
  assert_depth_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
  // R3: the overflow flag is set by a dropped write and then stays set
  assert_overflow_on_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |=> overflow);
  assert_overflow_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

endmodule

// File: rtl/sampler_lfsr.sv
module sampler_lfsr #(
  parameter int unsigned    W    = 32,
  parameter logic [W-1:0]   TAPS = 32'h8020_0003
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] seed,
  input  logic         adv,
  output logic [W-1:0] state,
  output logic [W-1:0] state_nxt
);
  logic [W-1:0] st_q, st_d;

  assign state_nxt = {1'b0, st_q[W-1:1]} ^ (st_q[0] ? TAPS : '0);
  assign state     = st_q;

  always_comb begin
    st_d = st_q;
    if (load)     st_d = seed;
    else if (adv) st_d = state_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= {{(W-1){1'b0}}, 1'b1};
    else        st_q <= st_d;
  end

endmodule

// File: rtl/sampler_core.sv
module sampler_core
  import pkt_sampler_pkg::*;
#(
  parameter int unsigned LEN_W = 16,
  parameter int unsigned W     = CFG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [LEN_W-1:0] pkt_len,
  input  logic             wr_ctrl,
  input  logic             wr_thr,
  input  logic             wr_seed,
  input  logic [W-1:0]     wdata,
  output logic             hit,
  output logic             en,
  output logic [1:0]       mode,
  output logic [W-1:0]     thr,
  output logic [W-1:0]     seed
);
  logic         en_q;
  smp_mode_e    mode_q;
  logic [W-1:0] thr_q, seed_q, acc_q, acc_d;
  logic         hit_q, hit_d;
  logic [W:0]   inc, sum, diff;
  logic         reach, gen_adv;
  logic [W-1:0] gen_q, gen_nxt;

  sampler_lfsr #(.W(W), .TAPS(GEN_TAPS)) u_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (wr_seed),
    .seed      (wdata),
    .adv       (gen_adv),
    .state     (gen_q),
    .state_nxt (gen_nxt)
  );

  assign inc   = (mode_q == MODE_COUNT) ? {{W{1'b0}}, 1'b1}
                                        : {{(W + 1 - LEN_W){1'b0}}, pkt_len};
  assign sum   = {1'b0, acc_q} + inc;
  assign diff  = sum - {1'b0, thr_q};
  assign reach = (sum >= {1'b0, thr_q});

  always_comb begin
    acc_d   = acc_q;
    hit_d   = hit_q;
    gen_adv = 1'b0;
    if (step) begin
      hit_d = 1'b0;
      if (en_q) begin
        case (mode_q)
          MODE_COUNT: begin
            hit_d = reach;
            acc_d = reach ? '0 : sum[W-1:0];
          end
          MODE_BYTES: begin
            hit_d = reach;
            acc_d = reach ? diff[W-1:0] : sum[W-1:0];
          end
          MODE_RANDOM: begin
            gen_adv = 1'b1;
            hit_d   = (gen_nxt >= thr_q);
          end
          default: ;
        endcase
      end
    end
    if (wr_ctrl) acc_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mode_q <= MODE_COUNT;
      thr_q  <= '0;
      seed_q <= {{(W-1){1'b0}}, 1'b1};
      acc_q  <= '0;
      hit_q  <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en_q   <= wdata[0];
        mode_q <= smp_mode_e'(wdata[2:1]);
      end
      if (wr_thr)  thr_q  <= wdata;
      if (wr_seed) seed_q <= wdata;
      acc_q <= acc_d;
      hit_q <= hit_d;
    end
  end

  assign hit  = hit_q;
  assign en   = en_q;
  assign mode = mode_q;
  assign thr  = thr_q;
  assign seed = seed_q;

  // R5: a disabled core stays silent and frozen
  assert_idle_core_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !en_q && !wr_ctrl && !wr_seed) |=> (!hit && $stable(acc_q) && $stable(gen_q)));
  // R11: mode 3 selects nothing and holds state
  assert_off_mode_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (step && en_q && mode_q == MODE_OFF && !wr_ctrl && !wr_seed)
      |=> (!hit && $stable(acc_q) && $stable(gen_q)));
  // R7: unit or zero threshold in count mode takes every packet
  assert_take_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && en_q && mode_q == MODE_COUNT && thr_q <= 1) |=> hit);
  // R10: seed write reloads the generator
  assert_seed_reload_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_seed |=> (gen_q == $past(wdata)));

endmodule

// File: rtl/pkt_sampler.sv
module pkt_sampler
  import pkt_sampler_pkg::*;
#(
  parameter int unsigned NUM_CORES  = 16,
  parameter int unsigned REC_W      = 32,
  parameter int unsigned LEN_W      = 16,
  parameter int unsigned FIFO_DEPTH = 8,
  parameter int unsigned WIN_CYCLES = 4,
  parameter int unsigned CORE_W     = $clog2(NUM_CORES),
  parameter int unsigned ADDR_W     = CORE_W + 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [REC_W-1:0]     in_record,
  input  logic [LEN_W-1:0]     in_len,
  output logic                 in_full,
  input  logic                 cfg_wr,
  input  logic [ADDR_W-1:0]    cfg_addr,
  input  logic [CFG_W-1:0]     cfg_wdata,
  output logic [CFG_W-1:0]     cfg_rdata,
  output logic                 res_valid,
  output logic [NUM_CORES-1:0] res_vector,
  output logic [REC_W-1:0]     res_record
);
  localparam int unsigned ENT_W = REC_W + LEN_W;
  localparam int unsigned PH_W  = $clog2(WIN_CYCLES);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(WIN_CYCLES - 1);

  logic [ENT_W-1:0] fifo_out;
  logic             fifo_empty, fifo_ovf, pop;
  logic [PH_W-1:0]  ph_q, ph_d;
  logic [REC_W-1:0] rec_q;
  logic [LEN_W-1:0] len_q;
  logic             step;

  sampler_fifo #(.W(ENT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (in_valid),
    .wdata    ({in_len, in_record}),
    .pop      (pop),
    .rdata    (fifo_out),
    .empty    (fifo_empty),
    .full     (in_full),
    .overflow (fifo_ovf)
  );

  // window scheduler
  assign pop  = (ph_q == '0) && !fifo_empty;
  assign step = (ph_q == PH_W'(1));

  always_comb begin
    if (ph_q == '0)         ph_d = pop ? PH_W'(1) : '0;
    else if (ph_q == PH_LAST) ph_d = '0;
    else                    ph_d = ph_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= '0;
      rec_q <= '0;
      len_q <= '0;
    end else begin
      ph_q <= ph_d;
      if (pop) begin
        rec_q <= fifo_out[REC_W-1:0];
        len_q <= fifo_out[ENT_W-1:REC_W];
      end
    end
  end

  assign res_valid  = (ph_q == PH_LAST);
  assign res_record = rec_q;

  // register decode
  logic             is_status;
  logic [CORE_W-1:0] core_sel;
  logic [1:0]       word_sel;
  assign is_status = cfg_addr[ADDR_W-1];
  assign core_sel  = cfg_addr[CORE_W+1:2];
  assign word_sel  = cfg_addr[1:0];

  logic             rb_en   [NUM_CORES];
  logic [1:0]       rb_mode [NUM_CORES];
  logic [CFG_W-1:0] rb_thr  [NUM_CORES];
  logic [CFG_W-1:0] rb_seed [NUM_CORES];

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
    logic sel_me;
    assign sel_me = cfg_wr && !is_status && (core_sel == CORE_W'(i));
    sampler_core #(.LEN_W(LEN_W), .W(CFG_W)) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (step),
      .pkt_len (len_q),
      .wr_ctrl (sel_me && word_sel == SEL_CTRL),
      .wr_thr  (sel_me && word_sel == SEL_THR),
      .wr_seed (sel_me && word_sel == SEL_SEED),
      .wdata   (cfg_wdata),
      .hit     (res_vector[i]),
      .en      (rb_en[i]),
      .mode    (rb_mode[i]),
      .thr     (rb_thr[i]),
      .seed    (rb_seed[i])
    );
  end

  always_comb begin
    cfg_rdata = '0;
    if (is_status) begin
      cfg_rdata[0] = fifo_ovf;
    end else begin
      case (word_sel)
        SEL_CTRL: cfg_rdata[2:0] = {rb_mode[core_sel], rb_en[core_sel]};
        SEL_THR:  cfg_rdata      = rb_thr[core_sel];
        SEL_SEED: cfg_rdata      = rb_seed[core_sel];
        default:  cfg_rdata      = '0;
      endcase
    end
  end

  // R4: the result strobe lasts one cycle
  assert_result_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  // R4: a pop is reported three cycles later
  if (WIN_CYCLES == 4) begin : g_lat_chk
    assert_pop_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> ##3 res_valid);
  end

endmodule

// File: tb/pkt_sampler_bench.sv
module pkt_sampler_bench;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int NC = 16;

  logic        clk, rst_n;
  logic        in_valid, in_full;
  logic [31:0] in_record;
  logic [15:0] in_len;
  logic        cfg_wr;
  logic [6:0]  cfg_addr;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic        res_valid;
  logic [15:0] res_vector;
  logic [31:0] res_record;

  pkt_sampler u_pkt_sampler (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_record(in_record),
    .in_len(in_len), .in_full(in_full), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .res_valid(res_valid),
    .res_vector(res_vector), .res_record(res_record)
  );

  int    checks = 0;
  int    fails  = 0;
  longint cyc   = 0;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // reference model
  logic        en_m   [NC];
  logic [1:0]  mode_m [NC];
  logic [31:0] thr_m  [NC];
  logic [31:0] acc_m  [NC];
  logic [31:0] gen_m  [NC];
  string       tag_m  [NC];

  typedef struct { logic [31:0] rec; logic [15:0] vec; } exp_t;
  exp_t   sb[$];
  longint vt[$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] gen_step(input logic [31:0] s);
    return {1'b0, s[31:1]} ^ (s[0] ? 32'h8020_0003 : 32'h0);
  endfunction

  function automatic logic [15:0] model_step(input logic [15:0] len);
    logic [15:0] v;
    logic [32:0] s;
    v = '0;
    for (int i = 0; i < NC; i++) begin
      if (en_m[i]) begin
        case (mode_m[i])
          2'd0: begin
            s = {1'b0, acc_m[i]} + 33'd1;
            if (s >= {1'b0, thr_m[i]}) begin v[i] = 1'b1; acc_m[i] = '0; end
            else acc_m[i] = s[31:0];
          end
          2'd1: begin
            s = {1'b0, acc_m[i]} + {17'd0, len};
            if (s >= {1'b0, thr_m[i]}) begin
              v[i] = 1'b1;
              s = s - {1'b0, thr_m[i]};
            end
            acc_m[i] = s[31:0];
          end
          2'd2: begin
            gen_m[i] = gen_step(gen_m[i]);
            v[i] = (gen_m[i] >= thr_m[i]);
          end
          default: ;
        endcase
      end
    end
    return v;
  endfunction

  function automatic logic [6:0] adr(input int core, input int sel);
    return {1'b0, core[3:0], sel[1:0]};
  endfunction

  task automatic cfg_write(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic cfg_read(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #0.5;
    d = cfg_rdata;
  endtask

  task automatic set_ctrl(input int c, input bit en, input logic [1:0] mode, input string tag);
    cfg_write(adr(c, 0), {29'd0, mode, en});
    en_m[c] = en; mode_m[c] = mode; acc_m[c] = '0; tag_m[c] = tag;
  endtask

  task automatic setup_core(input int c, input bit en, input logic [1:0] mode,
                            input logic [31:0] thr, input logic [31:0] seed, input string tag);
    cfg_write(adr(c, 1), thr);
    cfg_write(adr(c, 2), seed);
    thr_m[c] = thr; gen_m[c] = seed;
    set_ctrl(c, en, mode, tag);
  endtask

  longint last_push;
  task automatic send(input logic [31:0] rec, input logic [15:0] len, output bit acc);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; in_record = rec; in_len = len;
    acc = !in_full;
    last_push = cyc + 1;
    if (acc) begin
      e.rec = rec;
      e.vec = model_step(len);
      sb.push_back(e);
    end
    @(posedge clk);
  endtask

  task automatic stop_in();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    for (int k = 0; k < 400 && sb.size() != 0; k++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic paced(input int n, input int base);
    bit a;
    for (int k = 0; k < n; k++) begin
      send(32'hA000_0000 + base + k, 16'((k * 37 + base * 11) % 1500 + 40), a);
      stop_in();
      repeat (4) @(negedge clk);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      vt.push_back(cyc);
      if (sb.size() == 0) begin
        check(1'b0, "R4", "result with no packet pending", 64'(res_record), 64'h0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(res_record == e.rec, "R4", "record order", 64'(res_record), 64'(e.rec));
        for (int i = 0; i < NC; i++)
          check(res_vector[i] == e.vec[i], tag_m[i], $sformatf("core %0d verdict", i),
                64'(res_vector[i]), 64'(e.vec[i]));
      end
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    fails++;
    $display("FAIL watchdog run did not complete actual=0 expected=1");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    bit a;
    int acc_cnt;
    bit full_seen;
    longint p0;

    rst_n = 1'b0; in_valid = 1'b0; in_record = '0; in_len = '0;
    cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    for (int i = 0; i < NC; i++) begin
      en_m[i] = 0; mode_m[i] = 0; thr_m[i] = 0; acc_m[i] = 0; gen_m[i] = 1; tag_m[i] = "R5";
    end
    repeat (3) @(negedge clk);

    // R1 reset state
    check(res_valid == 1'b0, "R1", "res_valid in reset", 64'(res_valid), 64'h0);
    check(in_full == 1'b0, "R1", "in_full in reset", 64'(in_full), 64'h0);
    cfg_read(adr(0, 0), d);  check(d == 32'h0, "R1", "ctrl reset", 64'(d), 64'h0);
    cfg_read(adr(9, 1), d);  check(d == 32'h0, "R1", "threshold reset", 64'(d), 64'h0);
    cfg_read(adr(3, 2), d);  check(d == 32'h1, "R1", "seed reset", 64'(d), 64'h1);
    cfg_read(7'h40, d);      check(d == 32'h0, "R1", "status reset", 64'(d), 64'h0);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R12 register map readback
    cfg_write(adr(7, 0), 32'hFFFF_FFFD);
    cfg_read(adr(7, 0), d); check(d == 32'h5, "R12", "ctrl keeps bits 2:0", 64'(d), 64'h5);
    cfg_write(adr(7, 1), 32'h1234_5678);
    cfg_read(adr(7, 1), d); check(d == 32'h1234_5678, "R12", "threshold readback", 64'(d), 64'h1234_5678);
    cfg_write(adr(7, 2), 32'h0BAD_F00D);
    cfg_read(adr(7, 2), d); check(d == 32'h0BAD_F00D, "R12", "seed readback", 64'(d), 64'h0BAD_F00D);
    cfg_read(adr(6, 1), d); check(d == 32'h0, "R12", "neighbour untouched", 64'(d), 64'h0);

    // mixed configuration
    setup_core(0, 1, 2'd0, 32'd3,          32'h1,         "R6");
    setup_core(1, 1, 2'd0, 32'd1,          32'h1,         "R7");
    setup_core(2, 1, 2'd0, 32'd0,          32'h1,         "R7");
    setup_core(3, 1, 2'd1, 32'd1000,       32'h1,         "R8");
    setup_core(4, 1, 2'd2, 32'h8000_0000,  32'h0000_ACE1, "R9");
    setup_core(5, 0, 2'd0, 32'd1,          32'h1,         "R5");
    setup_core(6, 1, 2'd3, 32'd0,          32'h0F0F_1234, "R11");
    setup_core(7, 1, 2'd2, 32'hC000_0000,  32'h1234_5678, "R9");
    setup_core(8, 1, 2'd1, 32'd64,         32'h1,         "R8");
    setup_core(9, 0, 2'd2, 32'h4000_0000,  32'h5555_AAAA, "R5");
    setup_core(10, 1, 2'd0, 32'd5,         32'h1,         "R6");
    paced(24, 0);
    drain();

    // R5 / R11 frozen state: switch to random mode without reseeding
    set_ctrl(9, 1, 2'd2, "R5");
    set_ctrl(6, 1, 2'd2, "R11");
    thr_m[6] = 32'h0; cfg_write(adr(6, 1), 32'h6000_0000); thr_m[6] = 32'h6000_0000;
    // R10 reseed and counter clear
    cfg_write(adr(4, 2), 32'h0000_BEEF); gen_m[4] = 32'h0000_BEEF; tag_m[4] = "R10";
    set_ctrl(0, 1, 2'd0, "R10");
    paced(12, 100);
    drain();

    // R4 latency and spacing
    vt.delete();
    send(32'hC0DE_0001, 16'd100, a); p0 = last_push;
    send(32'hC0DE_0002, 16'd200, a);
    send(32'hC0DE_0003, 16'd300, a);
    stop_in();
    drain();
    check(vt.size() == 3, "R4", "pulse count", 64'(vt.size()), 64'd3);
    if (vt.size() == 3) begin
      check(vt[0] == p0 + 3, "R4", "first latency", 64'(vt[0] - p0), 64'd3);
      check(vt[1] - vt[0] == 4, "R4", "spacing 1", 64'(vt[1] - vt[0]), 64'd4);
      check(vt[2] - vt[1] == 4, "R4", "spacing 2", 64'(vt[2] - vt[1]), 64'd4);
    end

    // R2 / R3 overflow burst
    cfg_read(7'h40, d); check(d == 32'h0, "R3", "status before burst", 64'(d), 64'h0);
    acc_cnt = 0; full_seen = 0;
    for (int k = 0; k < 14; k++) begin
      send(32'hF000_0000 + k, 16'(50 + k), a);
      if (a) acc_cnt++; else full_seen = 1;
    end
    stop_in();
    check(full_seen, "R2", "in_full seen during burst", 64'(full_seen), 64'h1);
    check(acc_cnt == 11, "R2", "accepted writes", 64'(acc_cnt), 64'd11);
    cfg_read(7'h40, d); check(d == 32'h1, "R3", "overflow flag set", 64'(d), 64'h1);
    drain();
    cfg_read(7'h40, d); check(d == 32'h1, "R3", "overflow flag sticky", 64'(d), 64'h1);
    check(in_full == 1'b0, "R2", "full clears after drain", 64'(in_full), 64'h0);
    check(sb.size() == 0, "R4", "all results delivered", 64'(sb.size()), 64'h0);

    finish_run();
  end

endmodule